// File: doc/BRIEF.md
# Processor Core Reset Channel

This block owns the reset of one processor core and the request line for flushing that core's cache. Software reaches it through a plain 32-bit register port with two addresses: a control register and a timing register. Every write is masked bit by bit. A lower data bit lands in the register only if its partner bit sixteen places higher is 1 in the same write, so independent fields can be changed without a read first.

Setting the reset request runs a sequence. The core clock enable drops, the core reset rises, and the block waits a programmed number of timing ticks. The wait repeats with reset removed before the clock runs again. A build parameter picks one of two modes. In auto-clear mode the whole apply-and-remove sequence runs by itself and the request bit clears at the end. In manual mode the reset stays applied, with the clock running, until software writes the request to 0. A done flag records each completed removal, and software clears it by writing 1. The flush request is a separate bit. Software sets it, and it stays set until an external completion input is seen.

Top module: `cpu_rst_chan`

## Requirements
- R1: A write updates bit n (n in 0..15) of the addressed register only if bit n+16 of the same write data is 1. Otherwise bit n keeps its value. The timing register's stop count is bits [3:0], enabled by bits [19:16].
- R2: Address 0 reads the control register: reset request at bit 0, flush request at bit 4, done at bit 12, all other bits 0. Address 1 reads the stop count in bits [3:0], with all other bits 0.
- R3: After reset: core_rst is 0, core_clk_en is 1, flush_req is 0, the control register reads 0 and the stop count reads 15.
- R4: Auto-clear mode: writing the request bit to 1 from idle starts an apply phase and then a removal phase. Each phase lasts L+1 cycles when tick_en is held high, where L is the stop count. core_rst is 1 only during the apply phase, and core_clk_en is 0 during both phases. At the end the request bit reads 0 and done reads 1.
- R5: Manual mode: after the apply phase, core_rst stays 1 with core_clk_en 1 and the request bit reads 1. Writing the request to 0 starts a removal phase of L+1 gated cycles with core_rst 0. Done is then set.
- R6: core_rst is active high and changes value only in a cycle where core_clk_en is 0.
- R7: A gated phase does not end while tick_en is low (for L > 0).
- R8: A write to the request bit while a sequence is in a gated phase is ignored. In auto mode this holds for the whole sequence.
- R9: Done is cleared only by a control write with data bits 12 and 28 both 1. Any other write leaves it set.
- R10: Writing 1 to the flush request (bit 4, enable bit 20) sets flush_req, and writing 0 has no effect. The cycle after flush_done is seen with flush_req set, flush_req is 0. Done is not touched.
- R11: With a stop count of 0, each gated phase lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 1 | 0 selects control, 1 selects timing |
| bus_wdata | input | 32 | Write data, upper half is the per-bit write enable |
| bus_rdata | output | 32 | Read data of the addressed register |
| tick_en | input | 1 | One timing tick of the clock-stop timer |
| flush_done | input | 1 | Cache flush completed |
| core_rst | output | 1 | Core reset, active high |
| core_clk_en | output | 1 | Core clock enable |
| flush_req | output | 1 | Cache flush request |

## Verification
The assertions watch several rules on every cycle. A reset edge may only happen while the clock is gated. In auto mode reset never holds with the clock running. Done may rise only once the core is idle, and it survives any write that lacks its enable. A timing write without enables leaves the count untouched. The flush request holds until completion and drops right after. The lengths of the gated phases, the mode-dependent hold, the ignored mid-sequence writes and the masked read-back values need the bench's directed sequences and randomised masked writes to show them.

// File: rtl/cpu_rst_pkg.sv
// Shared definitions for the core reset channel.
// Assumes a 32-bit register port whose upper half-word is a write-enable mask.
package cpu_rst_pkg;
    localparam int REQ_BIT   = 0;
    localparam int FLUSH_BIT = 4;
    localparam int DONE_BIT  = 12;
    localparam int WEN_OFS   = 16;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_APPLY  = 2'd1,
        SEQ_HOLD   = 2'd2,
        SEQ_REMOVE = 2'd3
    } seq_state_t;
endpackage

// File: rtl/cpu_rst_tick_timer.sv
// Counts timing ticks during a clock-gated phase and flags when the
// programmed stop count is reached. Assumes the count restarts whenever
// gating is off or a phase has just expired.
module cpu_rst_tick_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gating,
    input  logic             tick_en,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    assign expired = gating && (cnt >= limit);

    // Tick counter, cleared between phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!gating || expired) begin
            cnt <= '0;
        end else if (tick_en) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cpu_rst_sequencer.sv
// Sequences the apply / hold / remove phases of the core reset.
// Assumes req_bit is the stored request; AUTO_CLEAR picks the mode.
module cpu_rst_sequencer
    import cpu_rst_pkg::*;
#(
    parameter bit AUTO_CLEAR = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_bit,
    input  logic expired,
    output logic gating,
    output logic seq_done,
    output logic req_wr_ok,
    output logic core_rst,
    output logic core_clk_en
);
    localparam seq_state_t AFTER_APPLY = AUTO_CLEAR ? SEQ_REMOVE : SEQ_HOLD;

    seq_state_t state, state_nx;

    // Next-state decode for the reset sequence.
    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_IDLE:   if (req_bit) state_nx = SEQ_APPLY;
            SEQ_APPLY:  if (expired) state_nx = AFTER_APPLY;
            SEQ_HOLD:   if (!req_bit) state_nx = SEQ_REMOVE;
            SEQ_REMOVE: if (expired) state_nx = SEQ_IDLE;
            default:    state_nx = SEQ_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= state_nx;
    end

    assign gating      = (state == SEQ_APPLY) || (state == SEQ_REMOVE);
    assign core_rst    = (state == SEQ_APPLY) || (state == SEQ_HOLD);
    assign core_clk_en = !gating;
    assign seq_done    = (state == SEQ_REMOVE) && expired;

    generate
        if (AUTO_CLEAR) begin : g_auto
            assign req_wr_ok = (state == SEQ_IDLE);
        end else begin : g_manual
            assign req_wr_ok = (state == SEQ_IDLE) || (state == SEQ_HOLD);
        end
    endgenerate
endmodule

// File: rtl/cpu_rst_regfile.sv
// Control and timing registers with per-bit masked writes.
// Assumes DATA_W is twice the mask offset; reads are combinational.
module cpu_rst_regfile
    import cpu_rst_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter int          CNT_W     = 4,
    parameter int unsigned CNT_RESET = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              req_wr_ok,
    input  logic              seq_done,
    input  logic              flush_done,
    output logic              req_bit,
    output logic              flush_bit,
    output logic              done_bit,
    output logic [CNT_W-1:0]  stop_cnt
);
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(CNT_RESET);

    logic ctrl_wr, tim_wr;
    logic unused_wdata;

    assign ctrl_wr      = bus_wr && !bus_addr;
    assign tim_wr       = bus_wr && bus_addr;
    assign unused_wdata = ^bus_wdata;

    // Reset request: masked write when allowed, cleared at sequence end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_bit <= 1'b0;
        end else if (seq_done) begin
            req_bit <= 1'b0;
        end else if (ctrl_wr && req_wr_ok && bus_wdata[WEN_OFS+REQ_BIT]) begin
            req_bit <= bus_wdata[REQ_BIT];
        end
    end

    // Flush request: set by software, cleared by completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_bit <= 1'b0;
        end else if (flush_bit && flush_done) begin
            flush_bit <= 1'b0;
        end else if (ctrl_wr && bus_wdata[WEN_OFS+FLUSH_BIT] && bus_wdata[FLUSH_BIT]) begin
            flush_bit <= 1'b1;
        end
    end

    // Done flag: set at sequence end, write-1-to-clear with enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_bit <= 1'b0;
        end else if (seq_done) begin
            done_bit <= 1'b1;
        end else if (ctrl_wr && bus_wdata[WEN_OFS+DONE_BIT] && bus_wdata[DONE_BIT]) begin
            done_bit <= 1'b0;
        end
    end

    // Stop count: one masked flop per bit.
    generate
        for (genvar i = 0; i < CNT_W; i++) begin : g_cnt_bit
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stop_cnt[i] <= CNT_INIT[i];
                end else if (tim_wr && bus_wdata[WEN_OFS+i]) begin
                    stop_cnt[i] <= bus_wdata[i];
                end
            end
        end
    endgenerate

    // Read mux; the enable half always reads 0.
    always_comb begin
        bus_rdata = '0;
        if (!bus_addr) begin
            bus_rdata[REQ_BIT]   = req_bit;
            bus_rdata[FLUSH_BIT] = flush_bit;
            bus_rdata[DONE_BIT]  = done_bit;
        end else begin
            bus_rdata[CNT_W-1:0] = stop_cnt;
        end
    end
endmodule

// File: rtl/cpu_rst_chan.sv
// Top of the core reset channel: registers, sequencer and tick timer.
// Assumes tick_en and flush_done are synchronous to clk.
module cpu_rst_chan #(
    parameter int          DATA_W     = 32,
    parameter int          CNT_W      = 4,
    parameter int unsigned CNT_RESET  = 15,
    parameter bit          AUTO_CLEAR = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_en,
    input  logic              flush_done,
    output logic              core_rst,
    output logic              core_clk_en,
    output logic              flush_req
);
    logic             req_bit, flush_bit, done_bit;
    logic             req_wr_ok, seq_done, gating, expired;
    logic [CNT_W-1:0] stop_cnt;

    assign flush_req = flush_bit;

    cpu_rst_regfile #(
        .DATA_W(DATA_W), .CNT_W(CNT_W), .CNT_RESET(CNT_RESET)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_wr_ok(req_wr_ok),
        .seq_done(seq_done), .flush_done(flush_done), .req_bit(req_bit),
        .flush_bit(flush_bit), .done_bit(done_bit), .stop_cnt(stop_cnt)
    );

    cpu_rst_sequencer #(.AUTO_CLEAR(AUTO_CLEAR)) u_seq (
        .clk(clk), .rst_n(rst_n), .req_bit(req_bit), .expired(expired),
        .gating(gating), .seq_done(seq_done), .req_wr_ok(req_wr_ok),
        .core_rst(core_rst), .core_clk_en(core_clk_en)
    );

    cpu_rst_tick_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .gating(gating), .tick_en(tick_en),
        .limit(stop_cnt), .expired(expired)
    );
endmodule

// File: rtl/cpu_rst_chan_chk.sv
// Property checker for the core reset channel, bound to the top.
module cpu_rst_chan_chk #(
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 4,
    parameter bit AUTO_CLEAR = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              flush_done,
    input logic              core_rst,
    input logic              core_clk_en,
    input logic              flush_req,
    input logic              done_bit,
    input logic [CNT_W-1:0]  stop_cnt
);
    p_timing_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr && (bus_wdata[16 +: CNT_W] == '0)) |=> $stable(stop_cnt));

    p_rst_edge_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rst != $past(core_rst)) |-> !core_clk_en);

    p_done_at_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_bit) |-> (core_clk_en && !core_rst));

    p_done_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_bit && !(bus_wr && !bus_addr && bus_wdata[28])) |=> done_bit);

    p_flush_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && !flush_done) |=> flush_req);

    p_flush_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && flush_done) |=> !flush_req);

    generate
        if (AUTO_CLEAR) begin : g_auto_chk
            p_auto_no_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
                core_rst |-> !core_clk_en);
        end
    endgenerate
endmodule

bind cpu_rst_chan cpu_rst_chan_chk #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .AUTO_CLEAR(AUTO_CLEAR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .flush_done(flush_done), .core_rst(core_rst),
    .core_clk_en(core_clk_en), .flush_req(flush_req), .done_bit(done_bit),
    .stop_cnt(stop_cnt)
);

// File: tb/cpu_rst_chan_test.sv
`timescale 1ns/1ps
module cpu_rst_chan_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_a = 1'b0, wr_m = 1'b0;
    logic        addr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata_a, rdata_m;
    logic        tick_en = 1'b1, fdone = 1'b0;
    logic        rst_a, clken_a, flush_a;
    logic        rst_m, clken_m, flush_m;
    int          n_chk = 0, n_fail = 0;
    bit          finished = 1'b0;

    always #4 clk = ~clk;

    cpu_rst_chan uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(wr_a), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata_a), .tick_en(tick_en), .flush_done(fdone),
        .core_rst(rst_a), .core_clk_en(clken_a), .flush_req(flush_a)
    );

    cpu_rst_chan #(.AUTO_CLEAR(1'b0)) uut_man (
        .clk(clk), .rst_n(rst_n), .bus_wr(wr_m), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata_m), .tick_en(tick_en), .flush_done(fdone),
        .core_rst(rst_m), .core_clk_en(clken_m), .flush_req(flush_m)
    );

    function automatic logic [3:0] masked_cnt(input logic [3:0] old, input logic [31:0] d);
        return (old & ~d[19:16]) | (d[3:0] & d[19:16]);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input bit man, input bit a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_a = !man; wr_m = man;
        @(negedge clk);
        wr_a = 1'b0; wr_m = 1'b0; wdata = '0;
    endtask

    task automatic rd(input bit man, input bit a, output logic [31:0] d);
        addr = a;
        #1;
        d = man ? rdata_m : rdata_a;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Runs an auto sequence already started; counts reset-high and gated samples.
    task automatic measure_auto(output int hi, output int gated);
        hi = 0; gated = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (rst_a) hi++;
            if (!clken_a) gated++;
            if (gated > 0 && clken_a && !rst_a) break;
        end
    endtask

    // Counts gated samples of the manual instance over n cycles, and reset-high among them.
    task automatic measure_man(input int n, output int gated, output int hi_gated);
        gated = 0; hi_gated = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!clken_m) begin
                gated++;
                if (rst_m) hi_gated++;
            end
        end
    endtask

    initial begin : watchdog
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] d;
        logic [3:0]  exp_cnt;
        int hi, gated, hig;
        void'($urandom(32'd20240611));

        wait_cyc(4);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 / R2: reset state
        rd(0, 0, d); check("R3 ctrl auto", d, 32'h0);
        rd(0, 1, d); check("R3 timing auto", d, 32'd15);
        rd(1, 0, d); check("R3 ctrl man", d, 32'h0);
        rd(1, 1, d); check("R2 timing man", d, 32'd15);
        check("R3 outputs", {29'd0, rst_a, clken_a, flush_a}, 32'b010);

        // R1: request without its enable bit does nothing
        wr(0, 0, 32'h0000_0001);
        wait_cyc(5);
        check("R1 no-enable rst", {31'd0, rst_a}, 32'd0);
        rd(0, 0, d); check("R1 no-enable ctrl", d, 32'h0);

        // R1 / R2: masked timing writes
        wr(0, 1, 32'h000F_0003); rd(0, 1, d); check("R2 timing write", d, 32'd3);
        wr(0, 1, 32'h0000_000C); rd(0, 1, d); check("R1 timing no enable", d, 32'd3);
        wr(0, 1, 32'h0002_0000); rd(0, 1, d); check("R1 timing single bit", d, 32'd1);
        wr(0, 1, 32'h000F_0003);
        wr(1, 1, 32'h000F_0003);

        // R4: auto sequence, L = 3
        wr(0, 0, 32'h0001_0001);
        measure_auto(hi, gated);
        check("R4 apply cycles", hi, 32'd4);
        check("R4 gated cycles", gated, 32'd8);
        rd(0, 0, d); check("R4 done and req cleared", d, 32'h0000_1000);

        // R9: done clear needs data bit 12 and enable bit 28
        wr(0, 0, 32'h0000_1000); rd(0, 0, d); check("R9 no enable", d, 32'h0000_1000);
        wr(0, 0, 32'h1000_0000); rd(0, 0, d); check("R9 enable only", d, 32'h0000_1000);
        wr(0, 0, 32'h1000_1000); rd(0, 0, d); check("R9 cleared", d, 32'h0);

        // R8: clearing the request mid-sequence is ignored in auto mode
        wr(0, 0, 32'h0001_0001);
        wr(0, 0, 32'h0001_0000);
        rd(0, 0, d); check("R8 req kept", d & 32'h1, 32'h1);
        measure_auto(hi, gated);
        rd(0, 0, d); check("R8 completes", d, 32'h0000_1000);
        hi = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (rst_a || !clken_a) hi++;
        end
        check("R8 no restart", hi, 32'd0);
        wr(0, 0, 32'h1000_1000);

        // R7: phase frozen while tick_en is low
        tick_en = 1'b0;
        wr(0, 0, 32'h0001_0001);
        wait_cyc(20);
        check("R7 frozen", {30'd0, rst_a, clken_a}, 32'b10);
        tick_en = 1'b1;
        measure_auto(hi, gated);
        rd(0, 0, d); check("R7 resumes", d, 32'h0000_1000);
        wr(0, 0, 32'h1000_1000);

        // R11: zero stop count
        wr(0, 1, 32'h000F_0000);
        wr(0, 0, 32'h0001_0001);
        measure_auto(hi, gated);
        check("R11 apply cycles", hi, 32'd1);
        check("R11 gated cycles", gated, 32'd2);
        wr(0, 0, 32'h1000_1000);

        // R10: flush handshake
        wr(0, 0, 32'h0010_0010);
        check("R10 flush set", {31'd0, flush_a}, 32'd1);
        rd(0, 0, d); check("R10 flush read", d, 32'h0000_0010);
        wait_cyc(5);
        wr(0, 0, 32'h0010_0000);
        check("R10 write 0 ignored", {31'd0, flush_a}, 32'd1);
        fdone = 1'b1;
        @(negedge clk);
        fdone = 1'b0;
        check("R10 flush cleared", {31'd0, flush_a}, 32'd0);
        rd(0, 0, d); check("R10 done untouched", d, 32'h0);

        // R5: manual mode hold and release, L = 3
        wr(1, 0, 32'h0001_0001);
        measure_man(12, gated, hig);
        check("R5 apply gated", gated, 32'd4);
        check("R5 hold outputs", {30'd0, rst_m, clken_m}, 32'b11);
        rd(1, 0, d); check("R5 held req", d, 32'h0000_0001);
        wr(1, 0, 32'h0001_0000);
        measure_man(12, gated, hig);
        check("R5 remove gated", gated, 32'd4);
        check("R5 remove rst low", hig, 32'd0);
        rd(1, 0, d); check("R5 done", d, 32'h0000_1000);
        wr(1, 0, 32'h1000_1000);

        // R8: manual clear during the apply phase is ignored
        wr(1, 0, 32'h0001_0001);
        wr(1, 0, 32'h0001_0000);
        wait_cyc(12);
        check("R8 manual still held", {31'd0, rst_m}, 32'd1);
        rd(1, 0, d); check("R8 manual req", d, 32'h0000_0001);
        wr(1, 0, 32'h0001_0000);
        wait_cyc(12);
        rd(1, 0, d); check("R8 manual release", d, 32'h0000_1000);

        // R1: random masked timing writes
        rd(0, 1, d);
        exp_cnt = d[3:0];
        for (int i = 0; i < 40; i++) begin
            logic [31:0] r;
            r = $urandom;
            wr(0, 1, r);
            exp_cnt = masked_cnt(exp_cnt, r);
            rd(0, 1, d);
            check("R1 random timing", d, {28'd0, exp_cnt});
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule